// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block produces all refresh traffic for a controller that drives an asynchronous DRAM. The DRAM advances its own internal row counter on every CAS-before-RAS cycle, so the block only shapes the two strobes and never supplies a row. After reset it keeps both strobes idle for a power-up pause. It then runs a fixed number of warm-up refresh cycles on its own, and only after that does it report that the memory is ready for normal access.

From then on an interval timer marks each point at which one refresh falls due. Each due refresh is recorded in a small saturating count of owed refreshes. While anything is owed the block holds a request to the access sequencer. The sequencer answers with a grant, which it keeps high until the request drops. The block then issues every owed refresh back to back. The write and output enables stay inactive at all times. All timing is expressed in clock cycles through parameters, and the defaults assume a 50 MHz clock.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While rst is high, and on the first sample after it, ras_n and cas_n are 1, ref_req is 0 and init_done is 0.
- R2: After reset is released, both strobes stay high for PWRUP_CYC clock edges, and cas_n first falls on edge PWRUP_CYC+1, counting the first edge after release as edge 1.
- R3: INIT_REFS refresh cycles then run back to back without any grant, and ref_req stays 0 throughout. init_done rises on edge PWRUP_CYC + INIT_REFS*T, where T = SETUP_CYC+RAS_LOW_CYC+PRECHG_CYC+1.
- R4: Once init_done is 1 it stays 1 until the next reset.
- R5: In every refresh, cas_n falls exactly SETUP_CYC cycles before ras_n falls, and cas_n stays 0 for as long as ras_n is 0.
- R6: Every low pulse on ras_n lasts exactly RAS_LOW_CYC cycles.
- R7: Between two refreshes, ras_n and cas_n are both 1 for at least PRECHG_CYC cycles.
- R8: Both bits of we_n and the signal oe_n are 1 at all times.
- R9: ref_req first rises exactly INTERVAL_CYC cycles after init_done rises. After that, one refresh falls due every INTERVAL_CYC cycles.
- R10: After initialisation, no refresh starts unless ref_gnt is 1. While refreshes are owed, ref_req stays 1 whether or not the grant is present.
- R11: Up to DEBT_MAX due refreshes are remembered, and any further ones are dropped. When a grant arrives, all n owed refreshes run back to back, and ref_req falls on edge n*T, counting the first granted edge as edge 1.
- R12: If ref_gnt is already 1 when ref_req rises, the refresh starts on the next edge, and ref_req stays 1 for exactly T cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Grant from the access sequencer; held high until ref_req drops |
| ref_req | output | 1 | Refresh owed; request for the memory bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 2 | Byte write enables, held inactive |
| oe_n | output | 1 | Output enable, held inactive |
| init_done | output | 1 | Power-up pause and warm-up refreshes finished |

## Verification
Every result is registered, so each one has a fixed due edge. The first CAS fall is due PWRUP_CYC+1 edges after reset release, and init_done is due PWRUP_CYC+8T edges after it. ref_req rises INTERVAL_CYC edges after init_done. A granted burst of n refreshes clears ref_req on edge n*T, counting from the first granted edge.

The bench changes inputs only on falling edges and samples on falling edges. It counts rising edges between an event and its result and compares that count with these formulas. A strobe monitor measures the length, in whole cycles, of every CAS setup, every RAS low pulse and every precharge gap.

// File: rtl/cbr_ref_pkg.sv
package cbr_ref_pkg;
  typedef enum logic [1:0] {ENG_IDLE, ENG_CAS, ENG_RAS, ENG_PRE} eng_state_t;
  typedef enum logic [1:0] {PH_PWRUP, PH_INIT, PH_RUN} phase_t;
endpackage

// File: rtl/ref_period_timer.sv
module ref_period_timer #(
  parameter int PERIOD = 780
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int W = $clog2(PERIOD + 1);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en)      cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/ref_debt_ctr.sv
module ref_debt_ctr #(
  parameter int MAX = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic owed
);
  localparam int W = $clog2(MAX + 1);
  localparam logic [W-1:0] TOP = W'(MAX);

  logic [W-1:0] cnt, cnt_nx;

  always_comb begin
    cnt_nx = cnt;
    case ({inc, dec})
      2'b10:   if (cnt != TOP) cnt_nx = cnt + 1'b1;
      2'b01:   if (cnt != '0)  cnt_nx = cnt - 1'b1;
      default: cnt_nx = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      owed <= 1'b0;
    end else begin
      cnt  <= cnt_nx;
      owed <= (cnt_nx != '0);
    end
  end
endmodule

// File: rtl/cbr_cycle_engine.sv
module cbr_cycle_engine
  import cbr_ref_pkg::*;
#(
  parameter int SETUP_CYC   = 1,
  parameter int RAS_LOW_CYC = 4,
  parameter int PRECHG_CYC  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic idle,
  output logic done,
  output logic ras_n,
  output logic cas_n
);
  localparam int MAXD = (SETUP_CYC > RAS_LOW_CYC)
                        ? ((SETUP_CYC > PRECHG_CYC) ? SETUP_CYC : PRECHG_CYC)
                        : ((RAS_LOW_CYC > PRECHG_CYC) ? RAS_LOW_CYC : PRECHG_CYC);
  localparam int CW = $clog2(MAXD + 1);

  eng_state_t     st, st_nx;
  logic [CW-1:0]  cnt, cnt_nx;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    done   = 1'b0;
    case (st)
      ENG_IDLE: if (start) begin
        st_nx  = ENG_CAS;
        cnt_nx = CW'(SETUP_CYC - 1);
      end
      ENG_CAS: if (cnt == '0) begin
        st_nx  = ENG_RAS;
        cnt_nx = CW'(RAS_LOW_CYC - 1);
      end else cnt_nx = cnt - 1'b1;
      ENG_RAS: if (cnt == '0) begin
        st_nx  = ENG_PRE;
        cnt_nx = CW'(PRECHG_CYC - 1);
      end else cnt_nx = cnt - 1'b1;
      ENG_PRE: if (cnt == '0) begin
        st_nx = ENG_IDLE;
        done  = 1'b1;
      end else cnt_nx = cnt - 1'b1;
      default: st_nx = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ENG_IDLE;
      cnt   <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
    end else begin
      st    <= st_nx;
      cnt   <= cnt_nx;
      ras_n <= (st_nx != ENG_RAS);
      cas_n <= !((st_nx == ENG_CAS) || (st_nx == ENG_RAS));
    end
  end

  assign idle = (st == ENG_IDLE);
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
  import cbr_ref_pkg::*;
#(
  parameter int PWRUP_CYC    = 5000,
  parameter int INIT_REFS    = 8,
  parameter int INTERVAL_CYC = 780,
  parameter int DEBT_MAX     = 8,
  parameter int SETUP_CYC    = 1,
  parameter int RAS_LOW_CYC  = 4,
  parameter int PRECHG_CYC   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_gnt,
  output logic       ref_req,
  output logic       ras_n,
  output logic       cas_n,
  output logic [1:0] we_n,
  output logic       oe_n,
  output logic       init_done
);
  localparam int IW = $clog2(INIT_REFS + 1);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_REFS - 1);

  phase_t        phase;
  logic [IW-1:0] init_cnt;
  logic          pwr_tick, int_tick;
  logic          eng_idle, eng_done, eng_start;
  logic          in_run;

  assign in_run = (phase == PH_RUN);

  ref_period_timer #(.PERIOD(PWRUP_CYC)) u_pwr_tmr (
    .clk(clk), .rst(rst), .en(phase == PH_PWRUP), .tick(pwr_tick));

  ref_period_timer #(.PERIOD(INTERVAL_CYC)) u_int_tmr (
    .clk(clk), .rst(rst), .en(in_run), .tick(int_tick));

  ref_debt_ctr #(.MAX(DEBT_MAX)) u_debt (
    .clk(clk), .rst(rst),
    .inc(in_run && int_tick), .dec(in_run && eng_done),
    .owed(ref_req));

  always_comb begin
    case (phase)
      PH_INIT: eng_start = eng_idle;
      PH_RUN:  eng_start = eng_idle && ref_req && ref_gnt;
      default: eng_start = 1'b0;
    endcase
  end

  cbr_cycle_engine #(
    .SETUP_CYC(SETUP_CYC), .RAS_LOW_CYC(RAS_LOW_CYC), .PRECHG_CYC(PRECHG_CYC)
  ) u_eng (
    .clk(clk), .rst(rst), .start(eng_start),
    .idle(eng_idle), .done(eng_done), .ras_n(ras_n), .cas_n(cas_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_PWRUP;
      init_cnt  <= '0;
      init_done <= 1'b0;
    end else begin
      case (phase)
        PH_PWRUP: if (pwr_tick) phase <= PH_INIT;
        PH_INIT: if (eng_done) begin
          init_cnt <= init_cnt + 1'b1;
          if (init_cnt == INIT_LAST) begin
            phase     <= PH_RUN;
            init_done <= 1'b1;
          end
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    we_n <= 2'b11;
    oe_n <= 1'b1;
  end
endmodule

// File: rtl/cbr_refresh_sched_chk.sv
module cbr_refresh_sched_chk #(
  parameter int RAS_LOW_CYC = 4
) (
  input logic clk,
  input logic rst,
  input logic ref_gnt,
  input logic ref_req,
  input logic ras_n,
  input logic cas_n,
  input logic init_done
);
  localparam int LW = $clog2(RAS_LOW_CYC + 2);
  localparam logic [LW-1:0] LIM = LW'(RAS_LOW_CYC);

  logic [LW-1:0] ras_lo_cnt;

  always_ff @(posedge clk) begin
    if (rst || ras_n)        ras_lo_cnt <= '0;
    else if (ras_lo_cnt <= LIM) ras_lo_cnt <= ras_lo_cnt + 1'b1;
  end

  AST_CAS_HELD_UNDER_RAS: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> !cas_n); // R5
  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> $past(!cas_n)); // R5
  AST_RAS_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    ras_lo_cnt <= LIM); // R6
  AST_REQ_AFTER_INIT: assert property (@(posedge clk) disable iff (rst)
    ref_req |-> init_done); // R3
  AST_INIT_STICKY: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done); // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_gnt) |=> ref_req); // R10
  AST_START_NEEDS_GNT: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_n) && $past(init_done)) |-> $past(ref_gnt)); // R10
endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk #(.RAS_LOW_CYC(RAS_LOW_CYC)) u_chk (
  .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req),
  .ras_n(ras_n), .cas_n(cas_n), .init_done(init_done));

// File: tb/tb_cbr_refresh_sched.sv
module tb_cbr_refresh_sched;
  localparam int PW  = 20;
  localparam int NI  = 8;
  localparam int IV  = 120;
  localparam int DM  = 8;
  localparam int S   = 1;
  localparam int RL  = 4;
  localparam int PC  = 3;
  localparam int T   = S + RL + PC + 1;
  localparam int ROWS = 4;
  localparam int HOLD_TAB [ROWS] = '{1, 3, 8, 11};
  localparam int EXP_TAB  [ROWS] = '{1, 3, 8, 8};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_gnt = 1'b0;
  logic ref_req, ras_n, cas_n, oe_n, init_done;
  logic [1:0] we_n;

  int n_checks = 0;
  int n_err = 0;
  int ras_falls = 0;
  bit en_bad = 1'b0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  cbr_refresh_sched #(
    .PWRUP_CYC(PW), .INIT_REFS(NI), .INTERVAL_CYC(IV), .DEBT_MAX(DM),
    .SETUP_CYC(S), .RAS_LOW_CYC(RL), .PRECHG_CYC(PC)
  ) dut (
    .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .init_done(init_done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  // strobe monitor
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  int cas_run = 0, ras_run = 0, hi_run = 0;
  bit seen_pulse = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      prev_ras = 1'b1; prev_cas = 1'b1;
      cas_run = 0; ras_run = 0; hi_run = 0; seen_pulse = 1'b0;
    end else begin
      if (we_n != 2'b11 || !oe_n) en_bad = 1'b1;
      if (prev_ras && !ras_n) begin
        ras_falls++;
        check(cas_run == S, "R5 cas setup cycles", cas_run, S);
      end
      if (!ras_n) check(!cas_n, "R5 cas low under ras", cas_n, 0);
      if (!prev_ras && ras_n) begin
        check(ras_run == RL, "R6 ras low width", ras_run, RL);
        seen_pulse = 1'b1;
      end
      if (prev_cas && !cas_n && seen_pulse)
        check(hi_run >= PC, "R7 precharge cycles", hi_run, PC);
      cas_run = (!cas_n && ras_n) ? cas_run + 1 : 0;
      ras_run = (!ras_n) ? ras_run + 1 : 0;
      hi_run  = (ras_n && cas_n) ? hi_run + 1 : 0;
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    int first_cas;
    int f0;
    bit req_seen;
    bit done_dropped;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(ras_n && cas_n, "R1 strobes high in reset", {ras_n, cas_n}, 3);
    check(!ref_req, "R1 ref_req low in reset", ref_req, 0);
    check(!init_done, "R1 init_done low in reset", init_done, 0);
    rst = 1'b0;

    // R2 / R3 power-up pause and warm-up
    n = 0; first_cas = -1; req_seen = 1'b0;
    while (!init_done && n < 1000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (!cas_n && first_cas < 0) first_cas = n;
      if (ref_req) req_seen = 1'b1;
    end
    check(first_cas == PW + 1, "R2 first cas fall edge", first_cas, PW + 1);
    check(n == PW + NI * T, "R3 init_done edge", n, PW + NI * T);
    check(ras_falls == NI, "R3 warm-up refresh count", ras_falls, NI);
    check(!req_seen, "R3 no request during init", req_seen, 0);

    // R9 first request
    n = 0; done_dropped = 1'b0;
    while (!ref_req && n < 1000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (!init_done) done_dropped = 1'b1;
    end
    check(n == IV, "R9 request after init_done", n, IV);

    // table walk: owed refreshes then grant
    for (int r = 0; r < ROWS; r++) begin
      f0 = ras_falls;
      req_seen = 1'b1;
      repeat ((HOLD_TAB[r] - 1) * IV + 30) begin
        @(posedge clk);
        @(negedge clk);
        if (!ref_req) req_seen = 1'b0;
        if (!init_done) done_dropped = 1'b1;
      end
      check(ras_falls == f0, "R10 no refresh without grant", ras_falls - f0, 0);
      check(req_seen, "R10 request held while ungranted", req_seen, 1);
      ref_gnt = 1'b1;
      n = 0;
      while (ref_req && n < 1000) begin
        @(posedge clk); n++;
        @(negedge clk);
      end
      ref_gnt = 1'b0;
      check(n == EXP_TAB[r] * T, "R11 burst length cycles", n, EXP_TAB[r] * T);
      check(ras_falls - f0 == EXP_TAB[r], "R11 refreshes issued", ras_falls - f0, EXP_TAB[r]);
      n = 0;
      while (!ref_req && n < 1000) begin
        @(posedge clk); n++;
        @(negedge clk);
      end
      if (r == 0) check(n == IV - 30 - T, "R9 next interval", n, IV - 30 - T);
    end

    // R12 grant waiting before the request
    ref_gnt = 1'b1;
    f0 = ras_falls;
    n = 0;
    while (ref_req && n < 1000) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    n = 0;
    while (!ref_req && n < 1000) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    f0 = ras_falls;
    n = 0;
    while (ref_req && n < 1000) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    check(n == T, "R12 pre-granted request length", n, T);
    check(ras_falls - f0 == 1, "R12 one refresh issued", ras_falls - f0, 1);
    ref_gnt = 1'b0;

    check(!done_dropped && init_done, "R4 init_done sticky", done_dropped, 0);
    check(!en_bad, "R8 write/output enables inactive", en_bad, 0);

    // R1 reset mid-run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(!init_done && !ref_req && ras_n && cas_n, "R1 state after re-reset",
          {init_done, ref_req, ras_n, cas_n}, 3);
    finish_run();
  end
endmodule